// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A clocked memory model holding words of 36 bits, arranged as four byte lanes of nine bits each. Addresses, controls and write data are captured on the rising clock edge. An access begins when either of two address strobes loads a new address. The processor-side strobe only counts while the chip enable is active, and it always starts a read. The controller-side strobe can start a read or a write. Once an access is open, each later cycle can step to the next word of a four-word burst or repeat the current word. The burst order is either linear or interleaved.

Read data passes through an output register, so the word for an address captured on one edge is driven after the following edge. The bidirectional data bus is modelled as separate input, output and output-enable ports. The drivers turn off at once when the output enable is high, when any write control is active, or when sleep is asserted. While sleeping the block holds all its state, and the array keeps its contents.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset every word of the array reads as zero and the output enable `q_oe_o` is low.
- R2: A new address is loaded on an edge where `cache_stb_ni` is low, or where `proc_stb_ni` is low and `chip_en_ni` is low. `proc_stb_ni` has no effect while `chip_en_ni` is high.
- R3: The block is selected only when `chip_en_ni`=0, `sel_hi_i`=1 and `sel_lo_ni`=0. A load while unselected closes any open burst and performs no access. The output stops driving after the next edge.
- R4: The word for an address accessed on edge k appears on `q_o`, with `q_oe_o` high, after edge k+1.
- R5: An access loaded through `proc_stb_ni` is a read whatever the write controls do on that edge. Write controls on the following edge apply to the burst as usual.
- R6: An access loaded through `cache_stb_ni` while `proc_stb_ni` is high is a write when write controls are active on that edge, and a read otherwise.
- R7: On an edge with no load and an open burst, `step_ni`=0 moves to the next burst word and `step_ni`=1 repeats the current word, for reads and writes alike.
- R8: The burst offset replaces address bits [1:0]. With `linear_i`=1 it is (base+n) mod 4; with `linear_i`=0 it is base XOR n. It returns to the base word after four words.
- R9: `wr_all_ni`=0 writes all four lanes whatever the lane controls are. Otherwise, with `lane_gate_ni`=0, each lane k with `lane_wr_ni[k]`=0 is written, and several lanes may be written together. With `lane_gate_ni`=1 the lane controls are blocked and the cycle is a read.
- R10: Lane k consists of data bits 8k..8k+7 together with bit 32+k.
- R11: `q_oe_o` is low in any cycle where a write control is active or `out_en_ni` is high, with no wait for a clock edge.
- R12: While `sleep_i` is high, edges change neither the array nor the pipeline state, and `q_oe_o` is low.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| proc_stb_ni | input | 1 | Processor-side address strobe, active low |
| cache_stb_ni | input | 1 | Controller-side address strobe, active low |
| chip_en_ni | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_hi_i | input | 1 | Chip select, active high |
| sel_lo_ni | input | 1 | Chip select, active low |
| step_ni | input | 1 | Burst advance, active low |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| wr_all_ni | input | 1 | Write all lanes, active low |
| lane_gate_ni | input | 1 | Enables the per-lane write controls, active low |
| lane_wr_ni | input | 4 | Per-lane write enables, active low |
| d_i | input | 36 | Write data |
| out_en_ni | input | 1 | Output enable, active low, acts at once |
| sleep_i | input | 1 | Sleep: freezes state and turns off the drivers |
| q_o | output | 36 | Read data from the output register |
| q_oe_o | output | 1 | Drive enable for q_o |

## Verification
The main overlap is a write that lands in the cycle where the previous read's word is still in the output register. The pipelined read wants to drive the bus while the write controls demand that it let go. The bench causes this by issuing writes and burst-continue writes right after reads. In those cycles it expects `q_oe_o` low. After the write, the pipeline must still deliver the following reads with the correct data. A second overlap is a burst step that coincides with a lane-masked write, which must update only the chosen lanes of the stepped address. Both are judged every cycle against a behavioural model of the array and the burst.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES     = 4;
  localparam int LANE_BITS = 8;
  localparam int PAR_BASE  = LANES * LANE_BITS;
  localparam int WORD_W    = LANES * (LANE_BITS + 1);
  localparam int BURST_W   = 2;

  // offset of the n-th burst word relative to the base
  function automatic logic [BURST_W-1:0] burst_off(input logic [BURST_W-1:0] base,
                                                   input logic [BURST_W-1:0] n,
                                                   input logic linear);
    return linear ? base + n : base ^ n;
  endfunction
endpackage

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_ni,
  input  logic              cache_stb_ni,
  input  logic              chip_en_ni,
  input  logic              sel_hi_i,
  input  logic              sel_lo_ni,
  input  logic              step_ni,
  input  logic              linear_i,
  input  logic              wr_all_ni,
  input  logic              lane_gate_ni,
  input  logic [LANES-1:0]  lane_wr_ni,
  output logic [LANES-1:0]  we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              wr_ctl_o,
  output logic              rd_pend_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nxt;
  logic               open_q;
  logic               sel, proc_start, load, go, is_wr;
  logic [LANES-1:0]   mask;
  logic [ADDR_W-1:0]  acc_addr;

  always_comb begin
    sel        = !chip_en_ni && sel_hi_i && !sel_lo_ni;
    proc_start = !proc_stb_ni && !chip_en_ni;
    load       = proc_start || !cache_stb_ni;
    if (!wr_all_ni)        mask = '1;
    else if (!lane_gate_ni) mask = ~lane_wr_ni;
    else                   mask = '0;
    cnt_nxt  = step_ni ? cnt_q : cnt_q + 1'b1;
    acc_addr = load ? addr_i
                    : {base_q[ADDR_W-1:BURST_W], burst_off(base_q[BURST_W-1:0], cnt_nxt, linear_i)};
    go       = load ? sel : open_q;
    is_wr    = go && (|mask) && !proc_start;
  end

  assign wr_ctl_o = |mask;
  assign we_o     = (run_i && is_wr) ? mask : '0;
  assign waddr_o  = acc_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      cnt_q     <= '0;
      open_q    <= 1'b0;
      rd_pend_o <= 1'b0;
      rd_addr_o <= '0;
    end else if (run_i) begin
      if (load) begin
        open_q <= sel;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (open_q) begin
        cnt_q  <= cnt_nxt;
      end
      rd_pend_o <= go && !is_wr;
      rd_addr_o <= acc_addr;
    end
  end

  assert_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load && open_q && !step_ni) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load && step_ni) |=> $stable(cnt_q));
  assert_proc_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && proc_start && sel) |=> rd_pend_o);
  assert_desel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && load && !sel) |=> (!rd_pend_o && !open_q));
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_BITS:0] bank [DEPTH];
    logic [LANE_BITS:0] rd_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
      end else if (we_i[k]) begin
        bank[waddr_i] <= {wdata_i[PAR_BASE+k], wdata_i[k*LANE_BITS +: LANE_BITS]};
      end
    end

    assign rd_w = bank[raddr_i];
    assign rdata_o[k*LANE_BITS +: LANE_BITS] = rd_w[LANE_BITS-1:0];
    assign rdata_o[PAR_BASE+k]               = rd_w[LANE_BITS];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_ni,
  input  logic              cache_stb_ni,
  input  logic              chip_en_ni,
  input  logic              sel_hi_i,
  input  logic              sel_lo_ni,
  input  logic              step_ni,
  input  logic              linear_i,
  input  logic              wr_all_ni,
  input  logic              lane_gate_ni,
  input  logic [LANES-1:0]  lane_wr_ni,
  input  logic [WORD_W-1:0] d_i,
  input  logic              out_en_ni,
  input  logic              sleep_i,
  output logic [WORD_W-1:0] q_o,
  output logic              q_oe_o
);
  logic              run;
  logic [LANES-1:0]  we;
  logic [ADDR_W-1:0] waddr, rd_addr;
  logic              wr_ctl, rd_pend;
  logic [WORD_W-1:0] rdata, out_q;
  logic              out_vld_q;

  assign run = !sleep_i;

  sbs_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk_i, .rst_ni, .run_i(run), .addr_i, .proc_stb_ni, .cache_stb_ni,
    .chip_en_ni, .sel_hi_i, .sel_lo_ni, .step_ni, .linear_i, .wr_all_ni,
    .lane_gate_ni, .lane_wr_ni, .we_o(we), .waddr_o(waddr), .wr_ctl_o(wr_ctl),
    .rd_pend_o(rd_pend), .rd_addr_o(rd_addr)
  );

  sbs_lane_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(d_i),
    .raddr_i(rd_addr), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else if (run) begin
      out_vld_q <= rd_pend;
      if (rd_pend) out_q <= rdata;
    end
  end

  assign q_o    = out_q;
  assign q_oe_o = out_vld_q && !out_en_ni && run && !wr_ctl;

  assert_single_desel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !rd_pend) |=> !out_vld_q);
  assert_sleep_freeze_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(out_q) && $stable(out_vld_q)));
  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && rd_pend) |=> out_vld_q);
endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic proc_n, cache_n, en_n, sel_hi, sel_lo_n, step_n, lin, wall_n, gate_n, oe_n, slp;
  logic [3:0] lwr_n;
  logic [35:0] d;
  logic [35:0] q;
  logic q_oe;

  always #5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_stb_ni(proc_n),
    .cache_stb_ni(cache_n), .chip_en_ni(en_n), .sel_hi_i(sel_hi), .sel_lo_ni(sel_lo_n),
    .step_ni(step_n), .linear_i(lin), .wr_all_ni(wall_n), .lane_gate_ni(gate_n),
    .lane_wr_ni(lwr_n), .d_i(d), .out_en_ni(oe_n), .sleep_i(slp), .q_o(q), .q_oe_o(q_oe)
  );

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  logic [35:0] m_mem [DEPTH];
  bit m_open, m_rdp, m_oval;
  int m_base, m_cnt, m_rda;
  logic [35:0] m_oreg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
      m_open = 0; m_rdp = 0; m_oval = 0; m_base = 0; m_cnt = 0; m_rda = 0; m_oreg = '0;
    end else if (!slp) begin
      int msk, a, lo;
      bit sel, pst, go, wr;
      m_oval = m_rdp;
      if (m_rdp) m_oreg = m_mem[m_rda];
      msk = !wall_n ? 15 : (!gate_n ? int'(~lwr_n) & 15 : 0);
      sel = !en_n && sel_hi && !sel_lo_n;
      pst = !proc_n && !en_n;
      if (pst || !cache_n) begin
        go = sel; a = int'(addr); wr = go && !pst && msk != 0;
        m_open = sel; m_base = int'(addr); m_cnt = 0;
      end else begin
        go = m_open;
        if (m_open && !step_n) m_cnt = (m_cnt + 1) % 4;
        lo = lin ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
        a = (m_base / 4) * 4 + lo;
        wr = go && msk != 0;
      end
      if (wr)
        for (int k = 0; k < 4; k++)
          if (msk[k]) begin
            m_mem[a][8*k +: 8] = d[8*k +: 8];
            m_mem[a][32+k] = d[32+k];
          end
      m_rdp = go && !wr;
      m_rda = a;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit wctl, eoe;
    wctl = !wall_n || (!gate_n && lwr_n != 4'hF);
    eoe = m_oval && !oe_n && !slp && !wctl;
    chk(q_oe === eoe, "q_oe", {35'd0, q_oe}, {35'd0, eoe});
    if (eoe) chk(q === m_oreg, "q", q, m_oreg);
  endtask

  task automatic idle_in();
    addr = '0; proc_n = 1; cache_n = 1; en_n = 0; sel_hi = 1; sel_lo_n = 0;
    step_n = 1; wall_n = 1; gate_n = 1; lwr_n = 4'hF; oe_n = 0; slp = 0; d = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic cwrite(input int a, input logic [35:0] v);
    idle_in(); cache_n = 0; addr = AW'(a); wall_n = 0; d = v; cyc();
  endtask

  task automatic cread(input int a);
    idle_in(); cache_n = 0; addr = AW'(a); cyc();
  endtask

  task automatic cont(input bit adv, input bit wr, input logic [35:0] v);
    idle_in(); step_n = !adv; if (wr) begin wall_n = 0; d = v; end cyc();
  endtask

  function automatic logic [35:0] pat(input int i);
    return {4'(i ^ 4'hA), 8'(i * 7 + 1), 8'(i * 13 + 5), 8'(i * 29 + 9), 8'(i * 3 + 2)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [35:0] v1, v2;
    idle_in(); lin = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    chk(q_oe === 1'b0, "reset q_oe", {35'd0, q_oe}, 36'd0);
    cread(5);
    chk(q_oe === 1'b0, "R4 not yet valid", {35'd0, q_oe}, 36'd0);
    cont(0, 0, '0);
    cur_req = "R4";
    chk(q_oe === 1'b1, "latency oe", {35'd0, q_oe}, 36'd1);
    chk(q === 36'd0, "R1 zero word", q, 36'd0);

    // R6 and R10: full write then lane writes
    cur_req = "R6";
    cwrite(4, pat(1));
    cread(4); cont(0, 0, '0);
    chk(q === pat(1), "R6 write/read", q, pat(1));
    cur_req = "R10";
    idle_in(); cache_n = 0; addr = 4; gate_n = 0; lwr_n = 4'b0101; d = pat(2); cyc();
    v1 = pat(1);
    v2 = pat(2);
    v1[15:8] = v2[15:8]; v1[33] = v2[33]; v1[31:24] = v2[31:24]; v1[35] = v2[35];
    cread(4); cont(0, 0, '0);
    chk(q === v1, "R10 lanes 1,3 merged", q, v1);

    // R9: global override and gate blocking
    cur_req = "R9";
    idle_in(); cache_n = 0; addr = 4; wall_n = 0; gate_n = 0; lwr_n = 4'b1110; d = pat(3); cyc();
    cread(4); cont(0, 0, '0);
    chk(q === pat(3), "R9 override all lanes", q, pat(3));
    idle_in(); cache_n = 0; addr = 4; gate_n = 1; lwr_n = 4'b0000; d = pat(4); cyc();
    cont(0, 0, '0);
    chk(q === pat(3), "R9 gate blocks, read", q, pat(3));

    // R5: processor strobe starts a read; next edge may write
    cur_req = "R5";
    idle_in(); proc_n = 0; addr = 4; wall_n = 0; d = pat(5); cyc();
    cont(0, 0, '0);
    chk(q === pat(3), "R5 proc read ignores write", q, pat(3));
    cont(0, 1, pat(6));
    cread(4); cont(0, 0, '0);
    chk(q === pat(6), "R5 write on following edge", q, pat(6));

    // R3: each select combination deselects
    cur_req = "R3";
    idle_in(); cache_n = 0; addr = 4; sel_hi = 0; cyc();
    cont(1, 0, '0);
    chk(q_oe === 1'b0, "R3 hi-z after deselect", {35'd0, q_oe}, 36'd0);
    idle_in(); cache_n = 0; sel_lo_n = 1; cyc(); cont(0, 0, '0);
    idle_in(); cache_n = 0; en_n = 1; cyc(); cont(0, 0, '0);
    cont(1, 1, pat(7));
    chk(q_oe === 1'b0, "R3 closed burst", {35'd0, q_oe}, 36'd0);

    // R2: processor strobe ignored with chip enable high
    cur_req = "R2";
    idle_in(); proc_n = 0; en_n = 1; addr = 4; cyc();
    cont(0, 0, '0);
    chk(q_oe === 1'b0, "R2 proc strobe ignored", {35'd0, q_oe}, 36'd0);
    idle_in(); proc_n = 0; addr = 4; cyc(); cont(0, 0, '0);
    chk(q === pat(6), "R2 proc load", q, pat(6));

    // R7 and R8: burst fill and reads in both orders
    cur_req = "R7";
    lin = 1;
    cwrite(8, pat(8));
    cont(1, 1, pat(9)); cont(1, 1, pat(10)); cont(1, 1, pat(11));
    cur_req = "R8";
    cread(10); cont(1, 0, '0);
    chk(q === pat(10), "R8 linear first", q, pat(10));
    cont(1, 0, '0);
    chk(q === pat(11), "R8 linear second", q, pat(11));
    cont(0, 0, '0);
    chk(q === pat(8), "R8 linear wrap to 8", q, pat(8));
    cont(1, 0, '0);
    cur_req = "R7";
    chk(q === pat(8), "R7 suspend repeats", q, pat(8));
    cont(1, 0, '0); cont(1, 0, '0);
    cur_req = "R8";
    chk(q === pat(10), "R8 returns to base", q, pat(10));
    lin = 0;
    cread(9); cont(1, 0, '0);
    cont(1, 0, '0);
    chk(q === pat(8), "R8 interleave 9->8", q, pat(8));
    cont(1, 0, '0);
    chk(q === pat(11), "R8 interleave 8->11", q, pat(11));
    cont(1, 0, '0); cont(0, 0, '0);
    // R7: burst write with lane mask and suspend
    cur_req = "R7";
    cread(13);
    idle_in(); step_n = 0; gate_n = 0; lwr_n = 4'b1100; d = pat(20); cyc();
    cont(0, 1, pat(21));
    cont(1, 1, pat(22));
    cread(12); cont(1, 0, '0); cont(1, 0, '0); cont(1, 0, '0); cont(1, 0, '0);

    // R11: output enable and write controls cut drivers
    cur_req = "R11";
    cread(9); cont(0, 0, '0);
    oe_n = 1; #1;
    chk(q_oe === 1'b0, "R11 async oe", {35'd0, q_oe}, 36'd0);
    oe_n = 0; #1;
    chk(q_oe === 1'b1, "R11 oe back", {35'd0, q_oe}, 36'd1);
    wall_n = 0; #1;
    chk(q_oe === 1'b0, "R11 write disables", {35'd0, q_oe}, 36'd0);
    wall_n = 1;
    cont(0, 0, '0);
    idle_in(); oe_n = 1; cyc();

    // R12: sleep freezes state and array
    cur_req = "R12";
    cread(8); cont(0, 0, '0);
    idle_in(); slp = 1; cache_n = 0; addr = 8; wall_n = 0; d = pat(30); cyc();
    chk(q_oe === 1'b0, "R12 hi-z asleep", {35'd0, q_oe}, 36'd0);
    cyc(); cyc();
    idle_in(); cache_n = 0; en_n = 1; cyc();
    cread(8); cont(0, 0, '0);
    chk(q === pat(8), "R12 array kept", q, pat(8));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule